// File: doc/BRIEF.md
# Configuration Address/Data Port Bridge

This block sits on a host I/O bus and gives the host indirect access to configuration space. The host first writes a 32-bit address word into an address latch at one I/O port. The word holds an enable flag, a bus number, a device/function number and a dword register number. The host then reads or writes through a four-byte data window. Each window access turns into one configuration request on a simple request/ready backend interface. The request carries the latched target fields, four byte enables and lane-aligned write data.

Host accesses use a one-cycle `io_req` pulse. `io_size` selects the access width: 0 is byte, 1 is word, and 2 or 3 is dword. Write data enters right-aligned on `io_wdata`, and read data comes back right-aligned on `io_rdata`. A host access finishes with a one-cycle `io_ack` pulse. The host must not issue a new request until that pulse has arrived, so a slow backend stalls the host. Local accesses are acknowledged in the cycle after the request. These are latch accesses, accesses to undecoded ports and window accesses made while the enable flag is clear.

Top module: `cfg_io_bridge`

## Requirements
- R1: After reset, `io_ack` and `cfg_req` are low and a dword read of the latch port (0xCF8) returns 0.
- R2: A dword write to the latch port stores the word. A dword read of the latch port returns bits 31:2 as written, with bits 1:0 read as zero.
- R3: A byte or word access to the latch port leaves the latch unchanged. Such a read returns all ones across the access width (0xFF or 0xFFFF), with zeros above that width.
- R4: When bit 31 of the latch is clear, a window access (ports 0xCFC to 0xCFF) raises no `cfg_req`. Such a write is dropped, and such a read returns all ones across the access width.
- R5: A request drives `cfg_bus` from latch bits 23:16, `cfg_devfn` from bits 15:8 and `cfg_reg` from bits 7:2.
- R6: A byte access at 0xCFC+n drives `cfg_be` = 1<<n and places the write byte in lane n (bits 8n+7:8n) of `cfg_wdata`.
- R7: For a word access, port bit 1 selects the half and port bit 0 is ignored. Bit 1 clear gives `cfg_be`=4'b0011 with the data in the low half. Bit 1 set gives 4'b1100 with the data in bits 31:16.
- R8: A dword window access drives `cfg_be`=4'b1111 and passes `io_wdata` through unshifted, whatever the two low port bits are.
- R9: A window read returns the selected lanes of `cfg_rdata`, shifted down to bit 0, with zeros above the access width.
- R10: `cfg_req` stays high with stable `cfg_we`, `cfg_be` and `cfg_wdata` until `cfg_ready` is sampled high. `io_ack` is then high for exactly the next cycle. With a ready delay of d cycles after the request appears, the ack arrives d+1 cycles after the request cycle, and it arrives in the cycle after the request for local accesses.
- R11: An access to any port outside the latch and the window is acknowledged with no request and no latch change. Such a read returns all ones across the access width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_req | input | 1 | One-cycle host access pulse |
| io_we | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | Host I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2/3 dword |
| io_wdata | input | 32 | Right-aligned host write data |
| io_rdata | output | 32 | Right-aligned read data, valid with io_ack |
| io_ack | output | 1 | One-cycle completion pulse |
| cfg_req | output | 1 | Configuration request, held until ready |
| cfg_we | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function |
| cfg_reg | output | 6 | Target dword register number |
| cfg_be | output | 4 | Byte enables of the request |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Backend read dword, valid with cfg_ready |
| cfg_ready | input | 1 | Backend completion pulse |

## Verification
The assertions assume two things about the host. It issues no new `io_req` while an access is pending, and it keeps `io_size` inside its two-bit code. They also assume that the backend raises `cfg_ready` only while `cfg_req` is high. The bench host task pulses `io_req` once and then waits for the acknowledge before it returns. The backend model answers only after it has seen a request, so the stimulus stays within these limits.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;
   localparam int CFG_DW  = 32;
   localparam int LANES   = CFG_DW / 8;
   localparam int LANE_W  = $clog2(LANES);

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_WORD  = 2'd1,
      SZ_DWORD = 2'd2,
      SZ_DWX   = 2'd3
   } cfgb_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_ACK  = 2'd2
   } cfgb_state_e;

   function automatic logic [CFG_DW-1:0] width_ones(input cfgb_size_e sz);
      case (sz)
         SZ_BYTE: width_ones = 32'h0000_00FF;
         SZ_WORD: width_ones = 32'h0000_FFFF;
         default: width_ones = 32'hFFFF_FFFF;
      endcase
   endfunction
endpackage

// File: rtl/cfgb_decode.sv
module cfgb_decode
   import cfgb_pkg::*;
#(
   parameter int              IO_AW       = 16,
   parameter logic [IO_AW-1:0] LATCH_PORT  = 16'h0CF8,
   parameter logic [IO_AW-1:0] WINDOW_PORT = 16'h0CFC
)(
   input  logic [IO_AW-1:0]  addr,
   input  cfgb_size_e        size,
   output logic              hit_latch,
   output logic              hit_window,
   output logic [LANE_W-1:0] lane,
   output logic [LANES-1:0]  be
);
   logic is_dword;
   assign is_dword = size[1];

   assign hit_latch  = (addr == LATCH_PORT) && is_dword;
   assign hit_window = (addr[IO_AW-1:LANE_W] == WINDOW_PORT[IO_AW-1:LANE_W]);

   always_comb begin
      if (is_dword) begin
         lane = '0;
         be   = '1;
      end else if (size == SZ_WORD) begin
         lane = {addr[1], 1'b0};
         be   = addr[1] ? 4'b1100 : 4'b0011;
      end else begin
         lane = addr[LANE_W-1:0];
         be   = LANES'(1) << addr[LANE_W-1:0];
      end
   end

   always_comb begin
      if (!$isunknown(be)) begin
         a_be_shape_r6: assert ($countones(be) == 1 || be == 4'b0011 ||
                                be == 4'b1100 || be == 4'b1111);
      end
   end
endmodule

// File: rtl/cfgb_lane_steer.sv
module cfgb_lane_steer
   import cfgb_pkg::*;
(
   input  logic [LANE_W-1:0] lane,
   input  cfgb_size_e        size,
   input  logic [CFG_DW-1:0] host_wdata,
   output logic [CFG_DW-1:0] lane_wdata,
   input  logic [CFG_DW-1:0] dev_rdata,
   output logic [CFG_DW-1:0] host_rdata
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LANE_W-1:0] wsrc;
      logic [LANE_W-1:0] rsrc;
      logic              keep;
      assign wsrc = LANE_W'(i) - lane;
      assign rsrc = LANE_W'(i) + lane;
      if (i == 0) begin : g_first
         assign keep = 1'b1;
      end else if (i == 1) begin : g_second
         assign keep = (size != SZ_BYTE);
      end else begin : g_upper
         assign keep = size[1];
      end
      assign lane_wdata[8*i +: 8] = host_wdata[{wsrc, 3'b000} +: 8];
      assign host_rdata[8*i +: 8] = keep ? dev_rdata[{rsrc, 3'b000} +: 8] : 8'h00;
   end
endmodule

// File: rtl/cfgb_addr_latch.sv
module cfgb_addr_latch
   import cfgb_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CFG_DW-1:0] wr_word,
   output logic [CFG_DW-1:0] word_q
);
   logic [CFG_DW-1:2] held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     held_q <= '0;
      else if (wr_en) held_q <= wr_word[CFG_DW-1:2];
   end

   assign word_q = {held_q, 2'b00};

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(word_q));
endmodule

// File: rtl/cfg_io_bridge.sv
module cfg_io_bridge
   import cfgb_pkg::*;
#(
   parameter int               IO_AW       = 16,
   parameter logic [IO_AW-1:0] LATCH_PORT  = 16'h0CF8,
   parameter logic [IO_AW-1:0] WINDOW_PORT = 16'h0CFC,
   parameter int               BUS_LSB     = 16,
   parameter int               BUS_W       = 8,
   parameter int               DEVFN_LSB   = 8,
   parameter int               DEVFN_W     = 8,
   parameter int               EN_BIT      = 31
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_req,
   input  logic              io_we,
   input  logic [IO_AW-1:0]  io_addr,
   input  logic [1:0]        io_size,
   input  logic [31:0]       io_wdata,
   output logic [31:0]       io_rdata,
   output logic              io_ack,
   output logic              cfg_req,
   output logic              cfg_we,
   output logic [BUS_W-1:0]  cfg_bus,
   output logic [DEVFN_W-1:0] cfg_devfn,
   output logic [DEVFN_LSB-LANE_W-1:0] cfg_reg,
   output logic [3:0]        cfg_be,
   output logic [31:0]       cfg_wdata,
   input  logic [31:0]       cfg_rdata,
   input  logic              cfg_ready
);
   localparam int REG_W = DEVFN_LSB - LANE_W;

   if (LATCH_PORT[LANE_W-1:0] != '0) begin : g_bad_latch
      $error("latch port must be dword aligned");
   end
   if (WINDOW_PORT[LANE_W-1:0] != '0) begin : g_bad_window
      $error("window port must be dword aligned");
   end
   if (BUS_LSB + BUS_W > EN_BIT || DEVFN_LSB + DEVFN_W > BUS_LSB) begin : g_bad_fields
      $error("address word fields overlap");
   end
   if (REG_W < 1) begin : g_bad_reg
      $error("register field empty");
   end

   cfgb_state_e        state_q;
   logic               we_q;
   logic [LANES-1:0]   be_q;
   logic [CFG_DW-1:0]  wdata_q;
   logic [LANE_W-1:0]  lane_q;
   cfgb_size_e         size_q;
   logic [CFG_DW-1:0]  rdata_q;

   cfgb_size_e         in_size;
   logic               hit_latch, hit_window;
   logic [LANE_W-1:0]  dec_lane;
   logic [LANES-1:0]   dec_be;
   logic [CFG_DW-1:0]  latch_word;
   logic               latch_wr;
   logic               cfg_en;
   logic [LANE_W-1:0]  steer_lane;
   cfgb_size_e         steer_size;
   logic [CFG_DW-1:0]  steered_w, steered_r;
   logic               accept;

   assign in_size = cfgb_size_e'(io_size);
   assign accept  = (state_q == ST_IDLE) && io_req;

   cfgb_decode #(
      .IO_AW(IO_AW), .LATCH_PORT(LATCH_PORT), .WINDOW_PORT(WINDOW_PORT)
   ) u_dec (
      .addr(io_addr), .size(in_size), .hit_latch(hit_latch),
      .hit_window(hit_window), .lane(dec_lane), .be(dec_be)
   );

   assign latch_wr = accept && io_we && hit_latch;

   cfgb_addr_latch u_latch (
      .clk(clk), .rst_n(rst_n), .wr_en(latch_wr),
      .wr_word(io_wdata), .word_q(latch_word)
   );

   assign cfg_en     = latch_word[EN_BIT];
   assign steer_lane = (state_q == ST_IDLE) ? dec_lane : lane_q;
   assign steer_size = (state_q == ST_IDLE) ? in_size  : size_q;

   cfgb_lane_steer u_steer (
      .lane(steer_lane), .size(steer_size), .host_wdata(io_wdata),
      .lane_wdata(steered_w), .dev_rdata(cfg_rdata), .host_rdata(steered_r)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         we_q    <= 1'b0;
         be_q    <= '0;
         wdata_q <= '0;
         lane_q  <= '0;
         size_q  <= SZ_BYTE;
         rdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (io_req) begin
                  if (hit_window && cfg_en) begin
                     state_q <= ST_WAIT;
                     we_q    <= io_we;
                     be_q    <= dec_be;
                     wdata_q <= steered_w;
                     lane_q  <= dec_lane;
                     size_q  <= in_size;
                  end else begin
                     state_q <= ST_ACK;
                     rdata_q <= hit_latch ? latch_word : width_ones(in_size);
                  end
               end
            end
            ST_WAIT: begin
               if (cfg_ready) begin
                  state_q <= ST_ACK;
                  rdata_q <= steered_r;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign io_ack    = (state_q == ST_ACK);
   assign io_rdata  = rdata_q;
   assign cfg_req   = (state_q == ST_WAIT);
   assign cfg_we    = we_q;
   assign cfg_be    = be_q;
   assign cfg_wdata = wdata_q;
   assign cfg_bus   = latch_word[BUS_LSB +: BUS_W];
   assign cfg_devfn = latch_word[DEVFN_LSB +: DEVFN_W];
   assign cfg_reg   = latch_word[LANE_W +: REG_W];

   p_req_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_req) |-> cfg_en);
   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req && !cfg_ready |=> cfg_req && $stable(cfg_be) && $stable(cfg_wdata) && $stable(cfg_we));
   p_ack_after_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req && cfg_ready |=> io_ack && !cfg_req);
   p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      io_ack |=> !io_ack);
   p_fields_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_req |=> $stable(cfg_bus) && $stable(cfg_devfn) && $stable(cfg_reg));
endmodule

// File: tb/sim_cfg_io_bridge.sv
module sim_cfg_io_bridge;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        io_req = 1'b0, io_we = 1'b0;
   logic [15:0] io_addr = '0;
   logic [1:0]  io_size = '0;
   logic [31:0] io_wdata = '0;
   logic [31:0] io_rdata;
   logic        io_ack;
   logic        cfg_req, cfg_we;
   logic [7:0]  cfg_bus, cfg_devfn;
   logic [5:0]  cfg_reg;
   logic [3:0]  cfg_be;
   logic [31:0] cfg_wdata;
   logic [31:0] cfg_rdata = '0;
   logic        cfg_ready = 1'b0;

   int n_tests = 0, n_fail = 0;
   int bk_count = 0, bk_delay = 0;
   logic [31:0] bk_data = 32'h4433_2211;
   logic        bk_we;
   logic [3:0]  bk_be;
   logic [31:0] bk_wdata;
   logic [7:0]  bk_bus, bk_devfn;
   logic [5:0]  bk_reg;
   int          last_wait;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_io_bridge u0 (
      .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_we(io_we),
      .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
      .io_rdata(io_rdata), .io_ack(io_ack), .cfg_req(cfg_req),
      .cfg_we(cfg_we), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
      .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .cfg_ready(cfg_ready)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   initial begin : backend
      forever begin
         @(negedge clk);
         if (cfg_req) begin
            bk_count++;
            bk_we = cfg_we; bk_be = cfg_be; bk_wdata = cfg_wdata;
            bk_bus = cfg_bus; bk_devfn = cfg_devfn; bk_reg = cfg_reg;
            repeat (bk_delay) @(negedge clk);
            cfg_ready = 1'b1;
            cfg_rdata = bk_data;
            @(negedge clk);
            cfg_ready = 1'b0;
            cfg_rdata = 32'hDEAD_BEEF;
         end
      end
   end

   task automatic io_op(input logic we, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
      int w = 0;
      @(negedge clk);
      io_req = 1'b1; io_we = we; io_addr = a; io_size = sz; io_wdata = wd;
      @(negedge clk);
      io_req = 1'b0;
      while (!io_ack && w < 1000) begin
         @(negedge clk);
         w++;
      end
      last_wait = w;
      rd = io_rdata;
   endtask

   function automatic logic [31:0] bemask(input logic [3:0] be);
      logic [31:0] m = '0;
      for (int i = 0; i < 4; i++) if (be[i]) m[8*i +: 8] = 8'hFF;
      return m;
   endfunction

   task automatic t_reset();
      logic [31:0] rd;
      check("R1 ack idle", {31'd0, io_ack}, 32'd0);
      check("R1 req idle", {31'd0, cfg_req}, 32'd0);
      io_op(1'b0, 16'h0CF8, 2'd2, 32'd0, rd);
      check("R1 latch reset", rd, 32'd0);
   endtask

   task automatic t_latch();
      logic [31:0] rd;
      io_op(1'b1, 16'h0CF8, 2'd2, 32'h8012_3457, rd);
      io_op(1'b0, 16'h0CF8, 2'd2, 32'd0, rd);
      check("R2 readback", rd, 32'h8012_3454);
      io_op(1'b1, 16'h0CF8, 2'd3, 32'h7FFF_FFFF, rd);
      io_op(1'b0, 16'h0CF8, 2'd2, 32'd0, rd);
      check("R2 readback low bits", rd, 32'h7FFF_FFFC);
   endtask

   task automatic t_latch_narrow();
      logic [31:0] rd;
      io_op(1'b1, 16'h0CF8, 2'd2, 32'h8000_1200, rd);
      io_op(1'b1, 16'h0CF8, 2'd0, 32'h0000_00AA, rd);
      io_op(1'b1, 16'h0CF8, 2'd1, 32'h0000_5555, rd);
      io_op(1'b0, 16'h0CF8, 2'd2, 32'd0, rd);
      check("R3 latch unchanged", rd, 32'h8000_1200);
      io_op(1'b0, 16'h0CF8, 2'd0, 32'd0, rd);
      check("R3 byte read ones", rd, 32'h0000_00FF);
      io_op(1'b0, 16'h0CF8, 2'd1, 32'd0, rd);
      check("R3 word read ones", rd, 32'h0000_FFFF);
   endtask

   task automatic t_disabled();
      logic [31:0] rd;
      int c0;
      io_op(1'b1, 16'h0CF8, 2'd2, 32'h0012_3400, rd);
      c0 = bk_count;
      io_op(1'b1, 16'h0CFC, 2'd2, 32'h1234_5678, rd);
      io_op(1'b0, 16'h0CFC, 2'd2, 32'd0, rd);
      check("R4 dword read ones", rd, 32'hFFFF_FFFF);
      io_op(1'b0, 16'h0CFE, 2'd0, 32'd0, rd);
      check("R4 byte read ones", rd, 32'h0000_00FF);
      check("R4 no request", bk_count, c0);
   endtask

   task automatic t_fields();
      logic [31:0] rd;
      bk_data = 32'hCAFE_F00D;
      io_op(1'b1, 16'h0CF8, 2'd2, 32'h80AB_CD7C, rd);
      io_op(1'b0, 16'h0CFC, 2'd2, 32'd0, rd);
      check("R5 bus", {24'd0, bk_bus}, 32'h0000_00AB);
      check("R5 devfn", {24'd0, bk_devfn}, 32'h0000_00CD);
      check("R5 reg", {26'd0, bk_reg}, 32'h0000_001F);
      check("R9 dword read", rd, 32'hCAFE_F00D);
      check("R8 read be", {28'd0, bk_be}, 32'h0000_000F);
   endtask

   task automatic t_byte();
      logic [31:0] rd;
      bk_data = 32'h4433_2211;
      io_op(1'b1, 16'h0CF8, 2'd2, 32'h8000_0010, rd);
      for (int n = 0; n < 4; n++) begin
         logic [7:0] v;
         v = 8'h5A + 8'(n);
         io_op(1'b1, 16'h0CFC + 16'(n), 2'd0, {24'hFFFFFF, v}, rd);
         check("R6 byte be", {28'd0, bk_be}, 32'(4'b0001 << n));
         check("R6 byte lane", bk_wdata & bemask(bk_be), 32'(v) << (8*n));
         check("R6 write flag", {31'd0, bk_we}, 32'd1);
         io_op(1'b0, 16'h0CFC + 16'(n), 2'd0, 32'd0, rd);
         check("R9 byte read", rd, (bk_data >> (8*n)) & 32'hFF);
      end
   endtask

   task automatic t_word();
      logic [31:0] rd;
      bk_data = 32'hA1B2_C3D4;
      io_op(1'b1, 16'h0CFC, 2'd1, 32'hFFFF_BEEF, rd);
      check("R7 low be", {28'd0, bk_be}, 32'h3);
      check("R7 low data", bk_wdata & bemask(bk_be), 32'h0000_BEEF);
      io_op(1'b1, 16'h0CFE, 2'd1, 32'h0000_1357, rd);
      check("R7 high be", {28'd0, bk_be}, 32'hC);
      check("R7 high data", bk_wdata & bemask(bk_be), 32'h1357_0000);
      io_op(1'b1, 16'h0CFF, 2'd1, 32'h0000_2468, rd);
      check("R7 bit0 ignored be", {28'd0, bk_be}, 32'hC);
      check("R7 bit0 ignored data", bk_wdata & bemask(bk_be), 32'h2468_0000);
      io_op(1'b0, 16'h0CFE, 2'd1, 32'd0, rd);
      check("R9 high word read", rd, 32'h0000_A1B2);
      io_op(1'b0, 16'h0CFD, 2'd1, 32'd0, rd);
      check("R9 low word read", rd, 32'h0000_C3D4);
   endtask

   task automatic t_dword();
      logic [31:0] rd;
      io_op(1'b1, 16'h0CFC, 2'd2, 32'h0BAD_F00D, rd);
      check("R8 be", {28'd0, bk_be}, 32'hF);
      check("R8 data", bk_wdata, 32'h0BAD_F00D);
      io_op(1'b1, 16'h0CFD, 2'd2, 32'h1122_3344, rd);
      check("R8 offset be", {28'd0, bk_be}, 32'hF);
      check("R8 offset data", bk_wdata, 32'h1122_3344);
   endtask

   task automatic t_stall();
      logic [31:0] rd;
      bk_delay = 5;
      bk_data = 32'h0F0E_0D0C;
      io_op(1'b0, 16'h0CFC, 2'd2, 32'd0, rd);
      check("R10 stall cycles", last_wait, 6);
      check("R10 read data", rd, 32'h0F0E_0D0C);
      @(negedge clk);
      check("R10 ack single", {31'd0, io_ack}, 32'd0);
      bk_delay = 0;
      io_op(1'b0, 16'h0CFC, 2'd2, 32'd0, rd);
      check("R10 zero delay", last_wait, 1);
      io_op(1'b0, 16'h0CF8, 2'd2, 32'd0, rd);
      check("R10 local ack", last_wait, 0);
   endtask

   task automatic t_other();
      logic [31:0] rd;
      int c0;
      c0 = bk_count;
      io_op(1'b1, 16'h03F8, 2'd2, 32'h0000_0000, rd);
      io_op(1'b1, 16'h0CF4, 2'd2, 32'h0000_0000, rd);
      io_op(1'b0, 16'h03FD, 2'd1, 32'd0, rd);
      check("R11 other read ones", rd, 32'h0000_FFFF);
      check("R11 no request", bk_count, c0);
      io_op(1'b0, 16'h0CF8, 2'd2, 32'd0, rd);
      check("R11 latch kept", rd, 32'h8000_0010);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_latch();
      t_latch_narrow();
      t_disabled();
      t_fields();
      t_byte();
      t_word();
      t_dword();
      t_stall();
      t_other();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule